// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block collects every interrupt source of a USB device controller and reduces them to a single processor interrupt line. Endpoint requests arrive as two vectors, one for the IN direction and one for the OUT direction, and are latched into one 32-bit endpoint pending register, the IN requests in the lower half and the OUT requests in the upper half. Device-level bus events arrive as single-cycle pulses and are latched into an 8-bit device pending register.

Each pending register has a companion mask register. A mask bit at 1 keeps its source from reaching the interrupt line, but the source is still recorded as pending. Software reads a pending register, handles the events, and writes the same value back to acknowledge, since both pending registers clear on a written one. The block also holds a bus-idle timer. When the line-state idle indication has been high for a programmable number of clock cycles, the timer raises the early-suspend device event. It raises it only once per idle stretch.

The register port is a plain four-word select with a write strobe. Read data is registered and follows the selected address by one clock. The interrupt output is registered too.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset both pending registers read 0, the endpoint mask reads 0x000F000F and the device mask reads 0x000000FF with the default four endpoints per direction, and `irq` is 0.
- R2: A pulse on IN request n sets endpoint pending bit n, and a pulse on OUT request n sets bit 16+n. Bits not tied to an existing endpoint always read 0.
- R3: The device pending bit positions are: 0 configuration selected, 1 interface selected, 2 early suspend, 3 bus reset, 4 suspend, 5 start of frame, 6 speed enumeration finished, 7 device status changed.
- R4: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If a source pulse and a write-1 clear of the same bit occur in the same cycle, the bit stays pending.
- R6: A mask bit at 1 stops its pending bit from driving `irq`, and the pending bit is still recorded. With every mask bit set, `irq` stays 0.
- R7: `irq` is registered. It goes high one clock after any unmasked pending bit exists, and goes low one clock after none remains.
- R8: The early-suspend event (device bit 2) is generated in the clock after `line_idle` has been sampled high on IDLE_CYCLES consecutive clock edges, so the pending bit is visible one clock after that.
- R9: The early-suspend event fires at most once per idle stretch. Any cycle with `line_idle` low restarts the count and re-arms the timer.
- R10: The mask registers are read/write. Only implemented bits are stored; the other bits read 0.
- R11: `bus_rdata` shows the register selected by `bus_addr` one clock later (0 endpoint pending, 1 endpoint mask, 2 device pending, 3 device mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_in_req | input | NEP | IN endpoint request pulses |
| ep_out_req | input | NEP | OUT endpoint request pulses |
| ev_set_cfg | input | 1 | Configuration-selected event pulse |
| ev_set_intf | input | 1 | Interface-selected event pulse |
| ev_bus_reset | input | 1 | Bus reset event pulse |
| ev_suspend | input | 1 | Suspend event pulse |
| ev_sof | input | 1 | Start-of-frame event pulse |
| ev_enum_done | input | 1 | Speed enumeration finished pulse |
| ev_status_chg | input | 1 | Device status changed pulse |
| line_idle | input | 1 | High while the bus line state is idle |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
The embedded assertions are evaluated on every clock. They check that a source pulse always wins over a same-cycle clear and that a write clears exactly the bits it names. They also check that the interrupt line follows the unmasked pending state one clock later, and that the early-suspend pulse lasts a single cycle and never fires during bus activity. Several behaviours need the bench's scenarios instead: the exact cycle count of the idle timer, the re-arming after activity, the endpoint bit mapping, the event bit positions and the reset values seen through the register port.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int REG_W    = 32;
  localparam int EP_HALF  = 16;
  localparam int DEV_W    = 8;
  localparam int DEV_EARLY_SUSP = 2;

  typedef enum logic [1:0] {
    RA_EP_PEND  = 2'd0,
    RA_EP_MASK  = 2'd1,
    RA_DEV_PEND = 2'd2,
    RA_DEV_MASK = 2'd3
  } reg_addr_e;

  function automatic logic [REG_W-1:0] ep_impl_bits(input int n);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < EP_HALF; i++) begin
      if (i < n) begin
        v[i]           = 1'b1;
        v[EP_HALF + i] = 1'b1;
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/usbirq_idle_timer.sv
module usbirq_idle_timer #(
  parameter int IDLE_CYCLES = 180000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_idle,
  output logic fire
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else if (!line_idle) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else if (!done && cnt == LAST) begin
      done <= 1'b1;
      fire <= 1'b1;
    end else begin
      fire <= 1'b0;
      if (!done) cnt <= cnt + 1'b1;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R9
  AST_FIRE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !line_idle |=> !fire); // R9
endmodule

// File: rtl/usbirq_srcbank.sv
module usbirq_srcbank #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         wr_pend,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic         active
);
  logic [W-1:0] clr;

  always_comb clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= IMPL;
    end else begin
      pend <= (src | (pend & ~clr)) & IMPL;
      if (wr_mask) mask <= wdata & IMPL;
    end
  end

  always_comb active = |(pend & ~mask);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((src & IMPL) != '0) |=> ((pend & $past(src & IMPL)) == $past(src & IMPL))); // R5
  AST_W1C_EXACT: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && src == '0) |=> (pend == ($past(pend) & ~$past(wdata)))); // R4
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((pend | mask) & ~IMPL) == '0); // R10
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
  import usbirq_pkg::*;
#(
  parameter int NEP         = 4,
  parameter int IDLE_CYCLES = 180000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEP-1:0]   ep_in_req,
  input  logic [NEP-1:0]   ep_out_req,
  input  logic             ev_set_cfg,
  input  logic             ev_set_intf,
  input  logic             ev_bus_reset,
  input  logic             ev_suspend,
  input  logic             ev_sof,
  input  logic             ev_enum_done,
  input  logic             ev_status_chg,
  input  logic             line_idle,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  localparam logic [REG_W-1:0] EP_IMPL  = ep_impl_bits(NEP);
  localparam logic [DEV_W-1:0] DEV_IMPL = '1;

  logic [REG_W-1:0] ep_src, ep_pend, ep_mask;
  logic [DEV_W-1:0] dev_src, dev_pend, dev_mask;
  logic             es_fire, ep_active, dev_active;
  reg_addr_e        sel;

  always_comb sel = reg_addr_e'(bus_addr);

  generate
    for (genvar i = 0; i < EP_HALF; i++) begin : g_ep_map
      if (i < NEP) begin : g_used
        assign ep_src[i]           = ep_in_req[i];
        assign ep_src[EP_HALF + i] = ep_out_req[i];
      end else begin : g_unused
        assign ep_src[i]           = 1'b0;
        assign ep_src[EP_HALF + i] = 1'b0;
      end
    end
  endgenerate

  always_comb dev_src = {ev_status_chg, ev_enum_done, ev_sof, ev_suspend,
                         ev_bus_reset, es_fire, ev_set_intf, ev_set_cfg};

  usbirq_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .line_idle(line_idle), .fire(es_fire)
  );

  usbirq_srcbank #(.W(REG_W), .IMPL(EP_IMPL)) u_ep (
    .clk(clk), .rst(rst), .src(ep_src),
    .wr_pend(bus_we && sel == RA_EP_PEND),
    .wr_mask(bus_we && sel == RA_EP_MASK),
    .wdata(bus_wdata), .pend(ep_pend), .mask(ep_mask), .active(ep_active)
  );

  usbirq_srcbank #(.W(DEV_W), .IMPL(DEV_IMPL)) u_dev (
    .clk(clk), .rst(rst), .src(dev_src),
    .wr_pend(bus_we && sel == RA_DEV_PEND),
    .wr_mask(bus_we && sel == RA_DEV_MASK),
    .wdata(bus_wdata[DEV_W-1:0]), .pend(dev_pend), .mask(dev_mask),
    .active(dev_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= ep_active | dev_active;
      unique case (sel)
        RA_EP_PEND:  bus_rdata <= ep_pend;
        RA_EP_MASK:  bus_rdata <= ep_mask;
        RA_DEV_PEND: bus_rdata <= {{(REG_W-DEV_W){1'b0}}, dev_pend};
        RA_DEV_MASK: bus_rdata <= {{(REG_W-DEV_W){1'b0}}, dev_mask};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(ep_active || dev_active) |=> !irq); // R6
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (ep_active || dev_active) |=> irq); // R7
endmodule

// File: tb/sim_usb_irq_aggregator.sv
`timescale 1ns/1ps
module sim_usb_irq_aggregator;
  localparam int NEP  = 4;
  localparam int IDLE = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NEP-1:0] ep_in_req = '0, ep_out_req = '0;
  logic [7:0] dev_ev = '0;
  logic line_idle = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  logic rd_req = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  usb_irq_aggregator #(.NEP(NEP), .IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rst(rst), .ep_in_req(ep_in_req), .ep_out_req(ep_out_req),
    .ev_set_cfg(dev_ev[0]), .ev_set_intf(dev_ev[1]), .ev_bus_reset(dev_ev[3]),
    .ev_suspend(dev_ev[4]), .ev_sof(dev_ev[5]), .ev_enum_done(dev_ev[6]),
    .ev_status_chg(dev_ev[7]), .line_idle(line_idle), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares each registered read against the queued expectation
  always @(posedge clk) begin
    if (rd_req) begin
      #1;
      if (exp_q.size() != 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd_check(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic irq_check(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic ep_pulse(input logic [NEP-1:0] i_v, input logic [NEP-1:0] o_v);
    @(negedge clk);
    ep_in_req = i_v; ep_out_req = o_v;
    @(negedge clk);
    ep_in_req = '0; ep_out_req = '0;
  endtask

  task automatic dev_pulse(input int idx);
    @(negedge clk);
    dev_ev[idx] = 1'b1;
    @(negedge clk);
    dev_ev = '0;
  endtask

  task automatic wait_edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values, R11 registered read by address
    irq_check(1'b0, "R1 irq after reset");
    rd_check(2'd0, 32'h0, "R1 ep pending reset");
    rd_check(2'd1, 32'h000F000F, "R1 ep mask reset");
    rd_check(2'd2, 32'h0, "R1 dev pending reset");
    rd_check(2'd3, 32'h000000FF, "R1 R11 dev mask reset");

    // R2 endpoint mapping; R6 masked source still pending, irq stays low
    ep_pulse(4'b0101, 4'b1000);
    rd_check(2'd0, 32'h00080005, "R2 ep bit mapping");
    irq_check(1'b0, "R6 all masked irq quiet");

    // R4 write-one-to-clear
    wr(2'd0, 32'h00000001);
    rd_check(2'd0, 32'h00080004, "R4 partial clear");
    wr(2'd0, 32'hFFFFFFFF);
    rd_check(2'd0, 32'h0, "R4 full clear");

    // R3 device event positions
    begin
      int pos[7] = '{0, 1, 3, 4, 5, 6, 7};
      foreach (pos[k]) begin
        dev_pulse(pos[k]);
        rd_check(2'd2, 32'h1 << pos[k], $sformatf("R3 dev event bit %0d", pos[k]));
        wr(2'd2, 32'hFF);
      end
    end
    rd_check(2'd2, 32'h0, "R4 dev cleared");

    // R10 mask read/write with unimplemented bits dropped
    wr(2'd1, 32'hFFFFFFFE);
    rd_check(2'd1, 32'h000F000E, "R10 ep mask write");

    // R7 irq timing: pulse sampled at edge A, pending at A, irq at A+1
    @(negedge clk);
    ep_in_req = 4'b0001;
    @(posedge clk); #1;
    ep_in_req = '0;
    irq_check(1'b0, "R7 irq not yet high");
    @(posedge clk); #1;
    irq_check(1'b1, "R7 irq high one clock after pending");
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 32'h1; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    irq_check(1'b1, "R7 irq still high at clear edge");
    @(posedge clk); #1;
    irq_check(1'b0, "R7 irq low one clock after clear");

    // R6 masked bit recorded but no irq
    ep_pulse(4'b0010, 4'b0000);
    wait_edges(2);
    irq_check(1'b0, "R6 masked source no irq");
    rd_check(2'd0, 32'h00000002, "R6 masked source pending");
    wr(2'd0, 32'hFFFFFFFF);

    // R5 set and clear collide
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 32'h1; bus_we = 1'b1; ep_in_req = 4'b0001;
    @(negedge clk);
    bus_we = 1'b0; ep_in_req = '0;
    rd_check(2'd0, 32'h00000001, "R5 set wins over clear");
    wr(2'd0, 32'hFFFFFFFF);
    wr(2'd1, 32'hFFFFFFFF);

    // R8 idle timer exact timing (early suspend unmasked)
    wr(2'd3, 32'h000000FB);
    @(negedge clk);
    line_idle = 1'b1;
    wait_edges(IDLE + 1);
    irq_check(1'b0, "R8 early suspend not yet");
    wait_edges(1);
    irq_check(1'b1, "R8 early suspend after idle window");
    rd_check(2'd2, 32'h04, "R8 early suspend pending bit 2");

    // R9 fires once per idle stretch
    wr(2'd2, 32'h04);
    wait_edges(3 * IDLE);
    rd_check(2'd2, 32'h0, "R9 no refire while idle");
    irq_check(1'b0, "R9 irq quiet while idle continues");

    // R9 activity restarts count: two interrupted stretches never fire
    @(negedge clk); line_idle = 1'b0;
    @(negedge clk); line_idle = 1'b1;
    wait_edges(IDLE - 4);
    @(negedge clk); line_idle = 1'b0;
    @(negedge clk); line_idle = 1'b1;
    wait_edges(IDLE - 4);
    @(negedge clk); line_idle = 1'b0;
    rd_check(2'd2, 32'h0, "R9 activity restarts count");

    // R9 re-armed after activity
    @(negedge clk); line_idle = 1'b1;
    wait_edges(IDLE + 4);
    rd_check(2'd2, 32'h04, "R9 rearmed after activity");
    irq_check(1'b1, "R9 irq after rearm");

    // R6 all masks set silences block
    wr(2'd3, 32'hFF);
    wait_edges(2);
    irq_check(1'b0, "R6 full mask silences irq");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule